// File: doc/BRIEF.md
# Charger Fault Latch and Interrupt Pulser

This block keeps the fault history of a battery charger for a host that polls over a serial bus. Live fault conditions (watchdog expiry, input overvoltage, thermal shutdown, safety-timer expiry, battery overvoltage) are folded into a sticky register. The register keeps each fault until the host reads it, even after the condition has gone away. A read returns the history. In the same cycle the register is reloaded with whatever is present at that moment, so an immediate second read reports the live state. A thermistor code is passed straight through to the readback byte and never latches.

The block also drives an active-low interrupt line as fixed-width pulses. A pulse is requested by any status-change strobe, and by a fault that arrives while the sticky register is empty. While unread faults sit in the register, further faults raise no interrupt. A request that arrives during a pulse is held as one pending pulse. That pulse follows after a single high cycle.

Top module: `fault_latch_irq`

## Requirements
- R1: After reset the sticky fault fields read 0 and `intN` is high.
- R2: Readback layout: bit 7 = watchdog expired, bit 6 reads 0, bits 5:4 = charge-fault code (00 none, 01 input fault, 10 thermal shutdown, 11 safety-timer expiry), bit 3 = battery overvoltage, bits 2:0 = thermistor code.
- R3: When several charge faults compete, thermal shutdown beats timer expiry, which beats input fault. This applies to simultaneous live conditions and to a latched code, which is replaced only by a higher-ranked one.
- R4: A latched fault bit or code stays set after its condition clears, until a read.
- R5: During a cycle with `faultRd` high, `faultData` shows the latched history. From the next cycle the register holds the conditions present in the read cycle, and it keeps accumulating from there.
- R6: Bits 2:0 follow `thermCode` combinationally, are never latched and never request an interrupt.
- R7: A pulse is requested when the sticky register is empty and any latchable condition is present. While the register is non-empty, faults request no pulse.
- R8: Any `statusEvt` bit high in a cycle requests a pulse.
- R9: A request seen at a clock edge while the pulser is idle drives `intN` low from that edge for exactly `PULSE_CYC` cycles.
- R10: Requests that arrive during a pulse collapse into one pending pulse. It starts after exactly one high cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wdExpired | input | 1 | Live watchdog-expired condition |
| inOverVolt | input | 1 | Live input fault condition |
| thermShut | input | 1 | Live thermal-shutdown condition |
| timerExpired | input | 1 | Live safety-timer expiry condition |
| batOverVolt | input | 1 | Live battery overvoltage condition |
| thermCode | input | 3 | Live thermistor fault code |
| statusEvt | input | NUM_EVT | Status-change event strobes |
| faultRd | input | 1 | Host read strobe for the fault register |
| faultData | output | 8 | Fault readback byte |
| intN | output | 1 | Active-low interrupt pulse |

## Verification
The assertions take all inputs to be synchronous to `clk`. They also take `faultRd` to be a strobe of one cycle per host access, because each high cycle counts as a separate read and reload. The stimulus changes every input one time unit after a falling edge and holds each read strobe for a single cycle. Status strobes are placed so that several of them land inside one pulse, which exercises the pending merge. A reference model in the bench predicts both outputs on every cycle.

// File: rtl/flt_pkg.sv
package flt_pkg;

  localparam int THERM_W = 3;

  typedef enum logic [1:0] {
    CHG_NONE    = 2'b00,
    CHG_INPUT   = 2'b01,
    CHG_THERMAL = 2'b10,
    CHG_TIMER   = 2'b11
  } chgCode_e;

  typedef struct packed {
    logic     wd;
    chgCode_e chg;
    logic     bat;
  } faultLat_t;

  // strobes from control to datapath
  typedef struct packed {
    logic reload;
    logic merge;
  } ctrlStrb_t;

  function automatic logic [1:0] chgRank(chgCode_e c);
    case (c)
      CHG_THERMAL: chgRank = 2'd3;
      CHG_TIMER:   chgRank = 2'd2;
      CHG_INPUT:   chgRank = 2'd1;
      default:     chgRank = 2'd0;
    endcase
  endfunction

  function automatic chgCode_e chgPick(chgCode_e held, chgCode_e incoming);
    chgPick = (chgRank(incoming) > chgRank(held)) ? incoming : held;
  endfunction

endpackage

// File: rtl/flt_datapath.sv
module flt_datapath
  import flt_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrb_t          strb,
  input  logic               wdExpired,
  input  logic               inOverVolt,
  input  logic               thermShut,
  input  logic               timerExpired,
  input  logic               batOverVolt,
  input  logic [THERM_W-1:0] thermCode,
  output logic               latchEmpty,
  output logic               liveAny,
  output logic [7:0]         faultData
);

  faultLat_t live;
  faultLat_t lat;
  faultLat_t latNext;

  always_comb begin
    live.wd  = wdExpired;
    live.bat = batOverVolt;
    if (thermShut)         live.chg = CHG_THERMAL;
    else if (timerExpired) live.chg = CHG_TIMER;
    else if (inOverVolt)   live.chg = CHG_INPUT;
    else                   live.chg = CHG_NONE;
  end

  always_comb begin
    latNext = lat;
    if (strb.reload) begin
      latNext = live;
    end else if (strb.merge) begin
      latNext.wd  = lat.wd  | live.wd;
      latNext.bat = lat.bat | live.bat;
      latNext.chg = chgPick(lat.chg, live.chg);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lat <= '{wd: 1'b0, chg: CHG_NONE, bat: 1'b0};
    else       lat <= latNext;
  end

  assign latchEmpty = !lat.wd && !lat.bat && (lat.chg == CHG_NONE);
  assign liveAny    = live.wd || live.bat || (live.chg != CHG_NONE);
  assign faultData  = {lat.wd, 1'b0, lat.chg, lat.bat, thermCode};

  a_r4_keep_wd: assert property (@(posedge clk) disable iff (!rstN)
    (strb.merge && !strb.reload && lat.wd) |=> lat.wd);

  a_r4_keep_bat: assert property (@(posedge clk) disable iff (!rstN)
    (strb.merge && !strb.reload && lat.bat) |=> lat.bat);

  a_r3_thermal_holds: assert property (@(posedge clk) disable iff (!rstN)
    (strb.merge && !strb.reload && lat.chg == CHG_THERMAL) |=> lat.chg == CHG_THERMAL);

  a_r5_reload_live: assert property (@(posedge clk) disable iff (!rstN)
    strb.reload |=> (lat.wd == $past(wdExpired) && lat.bat == $past(batOverVolt)));

endmodule

// File: rtl/flt_ctrl.sv
module flt_ctrl
  import flt_pkg::*;
#(
  parameter int PULSE_CYC = 32000,
  parameter int NUM_EVT   = 4
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic               rdStrobe,
  input  logic               latchEmpty,
  input  logic               liveAny,
  input  logic [NUM_EVT-1:0] statusEvt,
  output ctrlStrb_t          strb,
  output logic               intN
);

  localparam int CNT_W = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_CYC - 1);

  typedef enum logic [1:0] {P_IDLE, P_LOW, P_GAP} pState_e;

  pState_e          state;
  logic [CNT_W-1:0] cnt;
  logic             pend;
  logic             evtAny;
  logic             faultReq;
  logic             req;

  generate
    if (NUM_EVT == 1) begin : g_oneEvt
      assign evtAny = statusEvt[0];
    end else begin : g_manyEvt
      assign evtAny = |statusEvt;
    end
  endgenerate

  assign faultReq = latchEmpty && liveAny;
  assign req      = faultReq || evtAny;

  assign strb.reload = rdStrobe;
  assign strb.merge  = !rdStrobe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= P_IDLE;
      cnt   <= '0;
      pend  <= 1'b0;
    end else begin
      case (state)
        P_IDLE: begin
          if (req) begin
            state <= P_LOW;
            cnt   <= CNT_LOAD;
          end
        end
        P_LOW: begin
          if (req) pend <= 1'b1;
          if (cnt == '0) state <= P_GAP;
          else           cnt   <= cnt - 1'b1;
        end
        P_GAP: begin
          pend <= 1'b0;
          if (pend || req) begin
            state <= P_LOW;
            cnt   <= CNT_LOAD;
          end else begin
            state <= P_IDLE;
          end
        end
        default: state <= P_IDLE;
      endcase
    end
  end

  assign intN = (state != P_LOW);

  a_r9_hold_low: assert property (@(posedge clk) disable iff (!rstN)
    (state == P_LOW && cnt != '0) |=> !intN);

  a_r9_release: assert property (@(posedge clk) disable iff (!rstN)
    (state == P_LOW && cnt == '0) |=> intN);

  a_r10_pending_served: assert property (@(posedge clk) disable iff (!rstN)
    (state == P_LOW && cnt == '0 && pend) |=> intN ##1 !intN);

  a_r7_muted: assert property (@(posedge clk) disable iff (!rstN)
    (!latchEmpty && !evtAny && state == P_IDLE) |=> intN);

endmodule

// File: rtl/fault_latch_irq.sv
module fault_latch_irq
  import flt_pkg::*;
#(
  parameter int PULSE_CYC = 32000,
  parameter int NUM_EVT   = 4
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic               wdExpired,
  input  logic               inOverVolt,
  input  logic               thermShut,
  input  logic               timerExpired,
  input  logic               batOverVolt,
  input  logic [2:0]         thermCode,
  input  logic [NUM_EVT-1:0] statusEvt,
  input  logic               faultRd,
  output logic [7:0]         faultData,
  output logic               intN
);

  ctrlStrb_t strb;
  logic      latchEmpty;
  logic      liveAny;

  flt_ctrl #(
    .PULSE_CYC (PULSE_CYC),
    .NUM_EVT   (NUM_EVT)
  ) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .rdStrobe   (faultRd),
    .latchEmpty (latchEmpty),
    .liveAny    (liveAny),
    .statusEvt  (statusEvt),
    .strb       (strb),
    .intN       (intN)
  );

  flt_datapath uData (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .wdExpired    (wdExpired),
    .inOverVolt   (inOverVolt),
    .thermShut    (thermShut),
    .timerExpired (timerExpired),
    .batOverVolt  (batOverVolt),
    .thermCode    (thermCode),
    .latchEmpty   (latchEmpty),
    .liveAny      (liveAny),
    .faultData    (faultData)
  );

endmodule

// File: tb/sim_fault_latch_irq.sv
module sim_fault_latch_irq;

  localparam int W  = 6;
  localparam int NE = 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wdExpired = 0, inOverVolt = 0, thermShut = 0, timerExpired = 0, batOverVolt = 0;
  logic [2:0]    thermCode = 3'd0;
  logic [NE-1:0] statusEvt = '0;
  logic          faultRd = 1'b0;
  logic [7:0]    faultData;
  logic          intN;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  fault_latch_irq #(.PULSE_CYC(W), .NUM_EVT(NE)) u0 (
    .clk(clk), .rstN(rstN), .wdExpired(wdExpired), .inOverVolt(inOverVolt),
    .thermShut(thermShut), .timerExpired(timerExpired), .batOverVolt(batOverVolt),
    .thermCode(thermCode), .statusEvt(statusEvt), .faultRd(faultRd),
    .faultData(faultData), .intN(intN)
  );

  always #4 clk = ~clk;

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // reference model
  bit mWd, mBat;
  int mChg, mLow, mGap, mPend;

  function automatic int rk(int c);
    if (c == 2) return 3;
    if (c == 3) return 2;
    if (c == 1) return 1;
    return 0;
  endfunction

  always @(posedge clk) begin
    int liveChg;
    bit liveAnyM, emptyM, reqM;
    if (!rstN) begin
      mWd = 0; mBat = 0; mChg = 0; mLow = 0; mGap = 0; mPend = 0;
    end else begin
      liveChg  = thermShut ? 2 : timerExpired ? 3 : inOverVolt ? 1 : 0;
      liveAnyM = wdExpired || batOverVolt || (liveChg != 0);
      emptyM   = !mWd && !mBat && (mChg == 0);
      reqM     = (emptyM && liveAnyM) || (statusEvt != '0);
      if (faultRd) begin
        mWd = wdExpired; mBat = batOverVolt; mChg = liveChg;
      end else begin
        mWd  = mWd || wdExpired;
        mBat = mBat || batOverVolt;
        if (rk(liveChg) > rk(mChg)) mChg = liveChg;
      end
      if (mLow > 0) begin
        if (reqM) mPend = 1;
        mLow--;
        if (mLow == 0) mGap = 1;
      end else if (mGap) begin
        mGap = 0;
        if (mPend || reqM) mLow = W;
        mPend = 0;
      end else if (reqM) begin
        mLow = W;
      end
    end
  end

  // per-cycle comparison and pulse monitor
  logic prevIntN = 1'b1;
  int   falls = 0, runLen = 0, lastLen = 0;

  always @(negedge clk) begin
    if (rstN) begin
      logic [7:0] expData;
      expData = {mWd, 1'b0, 2'(mChg), mBat, thermCode};
      chk("R2/R4/R5 readback vs model", faultData, expData);
      chk("R9/R10 irq vs model", intN, (mLow == 0));
      if (prevIntN && !intN) falls++;
      if (!intN) runLen++;
      else if (!prevIntN) begin lastLen = runLen; runLen = 0; end
      prevIntN = intN;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog: got %0d expected <= 20000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    chk("R1 data after reset", faultData, 8'h00);
    chk("R1 irq after reset", intN, 1);

    base = falls;
    #1 timerExpired = 1;
    @(negedge clk);
    chk("R2 timer code", faultData, 8'h30);
    chk("R9 pulse starts", intN, 0);
    #1 timerExpired = 0;
    repeat (20) @(negedge clk);
    chk("R4 timer sticky", faultData, 8'h30);
    chk("R9 pulse length", lastLen, W);
    chk("R7 one fault pulse", falls - base, 1);

    #1 batOverVolt = 1;
    repeat (20) @(negedge clk);
    chk("R2 battery bit", faultData, 8'h38);
    chk("R7 muted while latched", falls - base, 1);

    #1 faultRd = 1;
    #1 chk("R5 read shows history", faultData, 8'h38);
    @(negedge clk);
    chk("R5 reload with live", faultData, 8'h08);
    #1 faultRd = 0; batOverVolt = 0;
    @(negedge clk);
    chk("R4 battery sticky", faultData, 8'h08);
    #1 faultRd = 1;
    @(negedge clk);
    chk("R5 second read clears", faultData, 8'h00);
    #1 faultRd = 0;
    repeat (20) @(negedge clk);
    chk("R7 no pulse from reads", falls - base, 1);

    base = falls;
    #1 thermShut = 1; timerExpired = 1; inOverVolt = 1;
    @(negedge clk);
    chk("R3 thermal wins", faultData, 8'h20);
    #1 thermShut = 0;
    repeat (3) @(negedge clk);
    chk("R3 thermal not displaced", faultData, 8'h20);
    #1 timerExpired = 0; inOverVolt = 0; faultRd = 1;
    @(negedge clk);
    chk("R5 cleared", faultData, 8'h00);
    #1 faultRd = 0;
    repeat (20) @(negedge clk);
    #1 inOverVolt = 1;
    @(negedge clk);
    chk("R2 input code", faultData, 8'h10);
    #1 inOverVolt = 0; timerExpired = 1;
    @(negedge clk);
    chk("R3 timer replaces input", faultData, 8'h30);
    #1 timerExpired = 0; faultRd = 1;
    @(negedge clk);
    #1 faultRd = 0;
    repeat (20) @(negedge clk);
    chk("R7 pulse per empty-latch fault", falls - base, 2);

    base = falls;
    #1 thermCode = 3'b101;
    #1 chk("R6 thermistor live", faultData, 8'h05);
    repeat (20) @(negedge clk);
    chk("R6 no thermistor pulse", falls - base, 0);
    #1 thermCode = 3'b000;
    #1 chk("R6 thermistor clears", faultData, 8'h00);

    base = falls;
    @(negedge clk);
    #1 statusEvt = 2'b01;
    @(negedge clk);
    chk("R8 event starts pulse", intN, 0);
    #1 statusEvt = 2'b00;
    @(negedge clk);
    #1 statusEvt = 2'b10;
    @(negedge clk);
    #1 statusEvt = 2'b01;
    @(negedge clk);
    #1 statusEvt = 2'b00;
    repeat (30) @(negedge clk);
    chk("R10 pending collapsed", falls - base, 2);
    chk("R9 pending pulse length", lastLen, W);

    #1 wdExpired = 1;
    @(negedge clk);
    chk("R2 watchdog bit", faultData, 8'h80);
    #1 wdExpired = 0; faultRd = 1;
    @(negedge clk);
    chk("R5 watchdog cleared", faultData, 8'h00);
    #1 faultRd = 0;
    repeat (20) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule